// File: doc/BRIEF.md
# Speculative Reorder Buffer

This block keeps in-flight instructions in program order between issue and retirement so that a core can execute speculatively and out of order while its architectural state changes only in order. The issue stage claims a slot at the tail and gets back a tag. A functional unit later reports the result on a single writeback port addressed by that tag. Exceptions and branch outcomes travel on the same port. The oldest entry retires from the head once its result has arrived.

Retirement writes the destination register, performs the memory write of a store, or reports a deferred exception. A branch that turned out to be mispredicted discards every entry and outputs the correct restart address. A lookup port lets the issue stage fetch a source operand from the youngest pending producer of a register. That value may be finished but not yet retired. The block handles one issue, one writeback and one retirement per cycle. It has 8 slots by default.

Top module: `reorder_buffer`

## Requirements
- R1: After reset the buffer is empty. `issue_ready` is 1 and `issue_tag` is 0. No retirement output is asserted, and a lookup reports no hit.
- R2: An instruction is accepted when `issue_valid` and `issue_ready` are both high. The kind codes are 0 for a register write, 1 for a store and 2 for a branch; code 3 is unused. The accepted entry's tag is the `issue_tag` shown in that cycle. Tags run 0, 1, 2 and so on, modulo the depth, from reset or from a flush. `issue_ready` is low while the buffer holds the full depth of entries.
- R3: A writeback with `wb_valid` to an in-flight tag marks that entry finished at the next edge. The head entry retires in the first cycle it is finished. A finished entry behind an unfinished head waits, and at most one entry retires per cycle.
- R4: A register-kind entry without an exception retires with `commit_reg_we` high. `commit_reg_idx` then carries its destination, and `commit_reg_data` carries its written-back `wb_value`.
- R5: For a store, `wb_value` carries the data and `wb_addr` carries the address. `commit_mem_we` is high, with that address and data, only in the cycle the store retires, and never earlier.
- R6: For a branch, `wb_addr` carries the correct target. A branch written back with `wb_mispredict` raises `flush` at retirement, with `flush_pc` equal to that target. A correctly predicted branch retires with no retirement output asserted.
- R7: An entry written back with `wb_exception` signals nothing until it reaches the head. When it retires, `exc_valid` and `flush` are both high, and no register or memory write occurs.
- R8: The lookup finds the youngest in-flight register-kind entry whose destination equals `opnd_reg`. It reports `opnd_hit` for that entry, and `opnd_ready` when the entry is finished. When the entry is finished, `opnd_value` is its result.
- R9: In a cycle with `flush` high, `issue_ready` is low and any writeback is ignored. At the next edge every entry is discarded, so the buffer is empty and `issue_tag` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | Instruction offered for allocation |
| issue_kind | input | 2 | 0 register write, 1 store, 2 branch |
| issue_dest | input | REG_W | Destination register of a register-kind entry |
| issue_ready | output | 1 | A slot can be taken this cycle |
| issue_tag | output | TAG_W | Slot the offered instruction receives |
| wb_valid | input | 1 | Result report valid |
| wb_tag | input | TAG_W | Entry the result belongs to |
| wb_value | input | DATA_W | Register result or store data |
| wb_addr | input | ADDR_W | Store address or correct branch target |
| wb_mispredict | input | 1 | Branch was predicted wrongly |
| wb_exception | input | 1 | Instruction raised an exception |
| opnd_reg | input | REG_W | Register whose pending value is looked up |
| opnd_hit | output | 1 | A pending producer exists |
| opnd_ready | output | 1 | That producer has finished |
| opnd_value | output | DATA_W | Producer's result |
| commit_reg_we | output | 1 | Register write at retirement |
| commit_reg_idx | output | REG_W | Register written |
| commit_reg_data | output | DATA_W | Value written |
| commit_mem_we | output | 1 | Memory write at retirement |
| commit_mem_addr | output | ADDR_W | Memory address |
| commit_mem_data | output | DATA_W | Memory data |
| flush | output | 1 | All entries discarded at the next edge |
| flush_pc | output | ADDR_W | Restart address for a mispredicted branch |
| exc_valid | output | 1 | Deferred exception reported at retirement |

## Verification
A corrupted head pointer shows up in the same cycle as a retirement of the wrong register index or value. A corrupted finished flag shows up as a retirement one or more cycles too early or too late compared with the writeback. A flush that does not fully clear state shows up at the very next cycle, because `issue_tag` is not 0 or a lookup still hits. A wrong age order in the lookup returns an older producer's value as soon as two pending entries share a destination. The bench runs a cycle-accurate queue model beside the design and compares every output every cycle, so any such error is reported in the cycle it first reaches a port.

// File: rtl/rob_pkg.sv
package rob_pkg;

    typedef enum logic [1:0] {
        ROB_KIND_REG    = 2'd0,
        ROB_KIND_STORE  = 2'd1,
        ROB_KIND_BRANCH = 2'd2,
        ROB_KIND_RSVD   = 2'd3
    } rob_kind_e;

endpackage

// File: rtl/rob_ptr_ctrl.sv
module rob_ptr_ctrl #(
    parameter int DEPTH = 8,
    localparam int TAG_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue_fire,
    input  logic             commit_fire,
    input  logic             flush,
    output logic [TAG_W-1:0] head,
    output logic [TAG_W-1:0] tail,
    output logic             full
);

    typedef struct packed {
        logic [TAG_W-1:0] head;
        logic [TAG_W-1:0] tail;
        logic [CNT_W-1:0] count;
    } ptr_state_t;

    ptr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (flush) begin
            st_d.head  = '0;
            st_d.tail  = '0;
            st_d.count = '0;
        end else begin
            if (commit_fire) begin
                st_d.head = st_q.head + 1'b1;
            end
            if (issue_fire) begin
                st_d.tail = st_q.tail + 1'b1;
            end
            st_d.count = st_q.count + CNT_W'(issue_fire) - CNT_W'(commit_fire);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign head = st_q.head;
    assign tail = st_q.tail;
    assign full = (st_q.count == CNT_W'(DEPTH));

    // R2
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.count <= CNT_W'(DEPTH));

    // R2
    ptr_consistent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        TAG_W'(st_q.tail - st_q.head) == TAG_W'(st_q.count));

    // R3
    head_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_fire && !flush) |=> st_q.head == TAG_W'($past(st_q.head) + 1'b1));

    // R9
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (st_q.count == '0 && st_q.head == '0 && st_q.tail == '0));

endmodule

// File: rtl/rob_commit_sel.sv
module rob_commit_sel
    import rob_pkg::*;
(
    input  logic      head_valid,
    input  logic      head_ready,
    input  rob_kind_e head_kind,
    input  logic      head_mispredict,
    input  logic      head_exception,
    output logic      commit_fire,
    output logic      reg_we,
    output logic      mem_we,
    output logic      flush,
    output logic      exc
);

    always_comb begin
        commit_fire = head_valid && head_ready;
        reg_we      = 1'b0;
        mem_we      = 1'b0;
        flush       = 1'b0;
        exc         = 1'b0;
        if (commit_fire) begin
            if (head_exception) begin
                exc   = 1'b1;
                flush = 1'b1;
            end else begin
                unique case (head_kind)
                    ROB_KIND_REG:    reg_we = 1'b1;
                    ROB_KIND_STORE:  mem_we = 1'b1;
                    ROB_KIND_BRANCH: flush  = head_mispredict;
                    default:         flush  = 1'b0;
                endcase
            end
        end
    end

endmodule

// File: rtl/rob_lookup.sv
module rob_lookup #(
    parameter int DEPTH  = 8,
    parameter int REG_W  = 5,
    parameter int DATA_W = 32,
    localparam int TAG_W = $clog2(DEPTH)
) (
    input  logic [TAG_W-1:0]  head,
    input  logic [REG_W-1:0]  req_reg,
    input  logic              cand_valid [DEPTH],
    input  logic [REG_W-1:0]  cand_dest  [DEPTH],
    input  logic              cand_ready [DEPTH],
    input  logic [DATA_W-1:0] cand_value [DEPTH],
    output logic              hit,
    output logic              ready,
    output logic [DATA_W-1:0] value
);

    logic [TAG_W-1:0] idx;

    // Walk from oldest to youngest; the last match found is the youngest.
    always_comb begin
        hit   = 1'b0;
        ready = 1'b0;
        value = '0;
        idx   = '0;
        for (int k = 0; k < DEPTH; k++) begin
            idx = head + TAG_W'(k);
            if (cand_valid[idx] && cand_dest[idx] == req_reg) begin
                hit   = 1'b1;
                ready = cand_ready[idx];
                value = cand_value[idx];
            end
        end
    end

endmodule

// File: rtl/reorder_buffer.sv
module reorder_buffer
    import rob_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int REG_W  = 5,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32,
    localparam int TAG_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_valid,
    input  logic [1:0]        issue_kind,
    input  logic [REG_W-1:0]  issue_dest,
    output logic              issue_ready,
    output logic [TAG_W-1:0]  issue_tag,
    input  logic              wb_valid,
    input  logic [TAG_W-1:0]  wb_tag,
    input  logic [DATA_W-1:0] wb_value,
    input  logic [ADDR_W-1:0] wb_addr,
    input  logic              wb_mispredict,
    input  logic              wb_exception,
    input  logic [REG_W-1:0]  opnd_reg,
    output logic              opnd_hit,
    output logic              opnd_ready,
    output logic [DATA_W-1:0] opnd_value,
    output logic              commit_reg_we,
    output logic [REG_W-1:0]  commit_reg_idx,
    output logic [DATA_W-1:0] commit_reg_data,
    output logic              commit_mem_we,
    output logic [ADDR_W-1:0] commit_mem_addr,
    output logic [DATA_W-1:0] commit_mem_data,
    output logic              flush,
    output logic [ADDR_W-1:0] flush_pc,
    output logic              exc_valid
);

    typedef struct packed {
        logic              valid;
        logic              ready;
        rob_kind_e         kind;
        logic [REG_W-1:0]  dest;
        logic [DATA_W-1:0] value;
        logic [ADDR_W-1:0] addr;
        logic              mispredict;
        logic              exception;
    } rob_entry_t;

    typedef struct packed {
        rob_entry_t [DEPTH-1:0] ent;
    } rob_state_t;

    rob_state_t       st_d, st_q;
    logic [TAG_W-1:0] head, tail;
    logic             full;
    logic             commit_fire;
    logic             flush_now;
    logic             issue_fire;
    rob_entry_t       head_ent;

    assign head_ent = st_q.ent[head];

    rob_commit_sel u_commit_sel (
        .head_valid      (head_ent.valid),
        .head_ready      (head_ent.ready),
        .head_kind       (head_ent.kind),
        .head_mispredict (head_ent.mispredict),
        .head_exception  (head_ent.exception),
        .commit_fire     (commit_fire),
        .reg_we          (commit_reg_we),
        .mem_we          (commit_mem_we),
        .flush           (flush_now),
        .exc             (exc_valid)
    );

    assign issue_ready = !full && !flush_now;
    assign issue_fire  = issue_valid && issue_ready;
    assign issue_tag   = tail;

    rob_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .issue_fire  (issue_fire),
        .commit_fire (commit_fire),
        .flush       (flush_now),
        .head        (head),
        .tail        (tail),
        .full        (full)
    );

    logic              lk_valid [DEPTH];
    logic [REG_W-1:0]  lk_dest  [DEPTH];
    logic              lk_ready [DEPTH];
    logic [DATA_W-1:0] lk_value [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_lk
        assign lk_valid[g] = st_q.ent[g].valid && (st_q.ent[g].kind == ROB_KIND_REG);
        assign lk_dest[g]  = st_q.ent[g].dest;
        assign lk_ready[g] = st_q.ent[g].ready;
        assign lk_value[g] = st_q.ent[g].value;
    end

    rob_lookup #(.DEPTH(DEPTH), .REG_W(REG_W), .DATA_W(DATA_W)) u_lookup (
        .head       (head),
        .req_reg    (opnd_reg),
        .cand_valid (lk_valid),
        .cand_dest  (lk_dest),
        .cand_ready (lk_ready),
        .cand_value (lk_value),
        .hit        (opnd_hit),
        .ready      (opnd_ready),
        .value      (opnd_value)
    );

    always_comb begin
        st_d = st_q;
        if (flush_now) begin
            for (int i = 0; i < DEPTH; i++) begin
                st_d.ent[i].valid = 1'b0;
                st_d.ent[i].ready = 1'b0;
            end
        end else begin
            if (wb_valid && st_q.ent[wb_tag].valid) begin
                st_d.ent[wb_tag].ready      = 1'b1;
                st_d.ent[wb_tag].value      = wb_value;
                st_d.ent[wb_tag].addr       = wb_addr;
                st_d.ent[wb_tag].mispredict = wb_mispredict;
                st_d.ent[wb_tag].exception  = wb_exception;
            end
            if (commit_fire) begin
                st_d.ent[head].valid = 1'b0;
                st_d.ent[head].ready = 1'b0;
            end
            if (issue_fire) begin
                st_d.ent[tail].valid      = 1'b1;
                st_d.ent[tail].ready      = 1'b0;
                st_d.ent[tail].kind       = rob_kind_e'(issue_kind);
                st_d.ent[tail].dest       = issue_dest;
                st_d.ent[tail].value      = '0;
                st_d.ent[tail].addr       = '0;
                st_d.ent[tail].mispredict = 1'b0;
                st_d.ent[tail].exception  = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign commit_reg_idx  = head_ent.dest;
    assign commit_reg_data = head_ent.value;
    assign commit_mem_addr = head_ent.addr;
    assign commit_mem_data = head_ent.value;
    assign flush           = flush_now;
    assign flush_pc        = head_ent.addr;

    // R6
    commit_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({commit_reg_we, commit_mem_we, flush}));

    // R7
    exc_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |-> (flush && !commit_reg_we && !commit_mem_we));

    // R9
    post_flush_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!commit_reg_we && !commit_mem_we && !flush && !opnd_hit && issue_tag == '0));

    // R2
    full_blocks_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !commit_fire) |=> $stable(tail));

endmodule

// File: tb/reorder_buffer_tb_top.sv
module reorder_buffer_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 8;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        issue_valid;
    logic [1:0]  issue_kind;
    logic [4:0]  issue_dest;
    logic        issue_ready;
    logic [2:0]  issue_tag;
    logic        wb_valid;
    logic [2:0]  wb_tag;
    logic [31:0] wb_value;
    logic [31:0] wb_addr;
    logic        wb_mispredict;
    logic        wb_exception;
    logic [4:0]  opnd_reg;
    logic        opnd_hit;
    logic        opnd_ready;
    logic [31:0] opnd_value;
    logic        commit_reg_we;
    logic [4:0]  commit_reg_idx;
    logic [31:0] commit_reg_data;
    logic        commit_mem_we;
    logic [31:0] commit_mem_addr;
    logic [31:0] commit_mem_data;
    logic        flush;
    logic [31:0] flush_pc;
    logic        exc_valid;

    always #(CLK_PERIOD / 2) clk = ~clk;

    reorder_buffer dut_i (
        .clk(clk), .rst_n(rst_n),
        .issue_valid(issue_valid), .issue_kind(issue_kind), .issue_dest(issue_dest),
        .issue_ready(issue_ready), .issue_tag(issue_tag),
        .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_value(wb_value), .wb_addr(wb_addr),
        .wb_mispredict(wb_mispredict), .wb_exception(wb_exception),
        .opnd_reg(opnd_reg), .opnd_hit(opnd_hit), .opnd_ready(opnd_ready), .opnd_value(opnd_value),
        .commit_reg_we(commit_reg_we), .commit_reg_idx(commit_reg_idx), .commit_reg_data(commit_reg_data),
        .commit_mem_we(commit_mem_we), .commit_mem_addr(commit_mem_addr), .commit_mem_data(commit_mem_data),
        .flush(flush), .flush_pc(flush_pc), .exc_valid(exc_valid)
    );

    int n_checks = 0;
    int n_errors = 0;

    // Reference queue built from the requirements
    bit        m_valid [DEPTH];
    bit        m_ready [DEPTH];
    int        m_kind  [DEPTH];
    bit [4:0]  m_dest  [DEPTH];
    bit [31:0] m_val   [DEPTH];
    bit [31:0] m_addr  [DEPTH];
    bit        m_mis   [DEPTH];
    bit        m_exc   [DEPTH];
    int        m_head, m_tail, m_cnt;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < DEPTH; i++) begin
            m_valid[i] = 1'b0;
            m_ready[i] = 1'b0;
        end
        m_head = 0;
        m_tail = 0;
        m_cnt  = 0;
    endtask

    task automatic step(input bit iv, input bit [1:0] ik, input bit [4:0] id,
                        input bit wv, input bit [2:0] wt, input bit [31:0] wd,
                        input bit [31:0] wa, input bit wm, input bit we,
                        input bit [4:0] lr);
        bit e_reg, e_mem, e_flush, e_exc, e_rdy, l_hit, l_rdy;
        bit [31:0] l_val;
        int h;
        @(negedge clk);
        issue_valid = iv; issue_kind = ik; issue_dest = id;
        wb_valid = wv; wb_tag = wt; wb_value = wd; wb_addr = wa;
        wb_mispredict = wm; wb_exception = we; opnd_reg = lr;
        #1;
        h = m_head;
        e_reg = 0; e_mem = 0; e_flush = 0; e_exc = 0;
        if (m_cnt > 0 && m_ready[h]) begin
            if (m_exc[h]) begin
                e_exc = 1; e_flush = 1;
            end else if (m_kind[h] == 0) e_reg = 1;
            else if (m_kind[h] == 1) e_mem = 1;
            else if (m_kind[h] == 2) e_flush = m_mis[h];
        end
        e_rdy = (m_cnt < DEPTH) && !e_flush;
        chk("R2 issue_ready", issue_ready, e_rdy);
        if (e_rdy) chk("R2 issue_tag", issue_tag, m_tail);
        chk("R4 commit_reg_we", commit_reg_we, e_reg);
        if (e_reg) begin
            chk("R4 commit_reg_idx", commit_reg_idx, m_dest[h]);
            chk("R4 commit_reg_data", commit_reg_data, m_val[h]);
        end
        chk("R5 commit_mem_we", commit_mem_we, e_mem);
        if (e_mem) begin
            chk("R5 commit_mem_addr", commit_mem_addr, m_addr[h]);
            chk("R5 commit_mem_data", commit_mem_data, m_val[h]);
        end
        chk("R6 flush", flush, e_flush);
        if (e_flush && !e_exc) chk("R6 flush_pc", flush_pc, m_addr[h]);
        chk("R7 exc_valid", exc_valid, e_exc);
        l_hit = 0; l_rdy = 0; l_val = 0;
        for (int k = 0; k < m_cnt; k++) begin
            int x;
            x = (m_head + k) % DEPTH;
            if (m_kind[x] == 0 && m_dest[x] == lr) begin
                l_hit = 1; l_rdy = m_ready[x]; l_val = m_val[x];
            end
        end
        chk("R8 opnd_hit", opnd_hit, l_hit);
        if (l_hit) chk("R8 opnd_ready", opnd_ready, l_rdy);
        if (l_hit && l_rdy) chk("R8 opnd_value", opnd_value, l_val);
        if (e_flush) begin
            model_clear();
        end else begin
            if (m_cnt > 0 && m_ready[h]) begin
                m_valid[h] = 0; m_ready[h] = 0;
                m_head = (m_head + 1) % DEPTH; m_cnt--;
            end
            if (wv && m_valid[wt]) begin
                m_ready[wt] = 1; m_val[wt] = wd; m_addr[wt] = wa;
                m_mis[wt] = wm; m_exc[wt] = we;
            end
            if (iv && e_rdy) begin
                m_valid[m_tail] = 1; m_ready[m_tail] = 0; m_kind[m_tail] = ik;
                m_dest[m_tail] = id; m_val[m_tail] = 0; m_addr[m_tail] = 0;
                m_mis[m_tail] = 0; m_exc[m_tail] = 0;
                m_tail = (m_tail + 1) % DEPTH; m_cnt++;
            end
        end
    endtask

    task automatic idle(input bit [4:0] lr);
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, lr);
    endtask

    task automatic issue(input bit [1:0] ik, input bit [4:0] id);
        step(1, ik, id, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic wback(input bit [2:0] wt, input bit [31:0] wd, input bit [31:0] wa,
                         input bit wm, input bit we);
        step(0, 0, 0, 1, wt, wd, wa, wm, we, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        bit iv, wv, wm, we;
        bit [1:0] ik;
        bit [4:0] id, lr;
        bit [2:0] wt;
        int ta, tb;
        void'($urandom(32'd20051010));
        issue_valid = 0; issue_kind = 0; issue_dest = 0; wb_valid = 0; wb_tag = 0;
        wb_value = 0; wb_addr = 0; wb_mispredict = 0; wb_exception = 0; opnd_reg = 0;
        model_clear();
        rst_n = 0;
        repeat (3) @(posedge clk);
        rst_n = 1;
        @(negedge clk); #1;
        chk("R1 reset issue_ready", issue_ready, 1);
        chk("R1 reset issue_tag", issue_tag, 0);
        chk("R1 reset retire idle", {commit_reg_we, commit_mem_we, flush, exc_valid}, 0);
        chk("R1 reset lookup miss", opnd_hit, 0);

        // Fill to capacity, then out-of-order finish
        for (int i = 0; i < DEPTH; i++) issue(0, 5'(i + 1));
        step(1, 0, 9, 0, 0, 0, 0, 0, 0, 0);
        chk("R2 full blocks issue", issue_ready, 0);
        wback(5, 55, 0, 0, 0);
        idle(6);
        chk("R3 younger waits for head", commit_reg_we, 0);
        chk("R8 finished uncommitted value", opnd_value, 55);
        wback(0, 100, 0, 0, 0);
        idle(0);
        chk("R3 head retires after writeback", commit_reg_we, 1);
        chk("R4 head data", commit_reg_data, 100);
        for (int t = 1; t < DEPTH; t++) wback(3'(t), 32'(t * 3), 0, 0, 0);
        repeat (10) idle(0);

        // Youngest producer wins
        ta = m_tail; issue(0, 3);
        tb = m_tail; issue(0, 3);
        wback(3'(ta), 7, 0, 0, 0);
        idle(3);
        chk("R8 youngest not finished", opnd_ready, 0);
        wback(3'(tb), 8, 0, 0, 0);
        idle(3);
        chk("R8 youngest value", opnd_value, 8);
        repeat (3) idle(0);

        // Store retires only at the head
        ta = m_tail; issue(1, 0);
        wback(3'(ta), 32'hABCD, 32'h100, 0, 0);
        chk("R5 no memory write before retire", commit_mem_we, 0);
        idle(0);
        chk("R5 memory write at retire", commit_mem_addr, 32'h100);

        // Mispredicted branch, with writeback and issue during the flush cycle
        ta = m_tail; issue(2, 0);
        tb = m_tail; issue(0, 12);
        wback(3'(ta), 0, 32'h400, 1, 0);
        step(1, 0, 13, 1, 3'(tb), 77, 0, 0, 0, 12);
        chk("R6 flush on mispredict", flush, 1);
        chk("R6 restart address", flush_pc, 32'h400);
        chk("R9 no issue during flush", issue_ready, 0);
        idle(12);
        chk("R9 empty after flush", opnd_hit, 0);
        chk("R9 tag restarts", issue_tag, 0);

        // Correct branch retires silently
        ta = m_tail; issue(2, 0);
        wback(3'(ta), 0, 32'h800, 0, 0);
        idle(0);
        chk("R6 correct branch silent", {commit_reg_we, commit_mem_we, flush}, 0);

        // Deferred exception
        ta = m_tail; issue(0, 4);
        wback(3'(ta), 9, 0, 0, 1);
        chk("R7 nothing before head", exc_valid, 0);
        idle(0);
        chk("R7 exception at retire", exc_valid, 1);
        chk("R7 no register write", commit_reg_we, 0);

        // Constrained random traffic
        for (int c = 0; c < 4000; c++) begin
            iv = ($urandom % 4) != 0;
            ik = 2'($urandom % 3);
            id = 5'($urandom % 8);
            lr = 5'($urandom % 8);
            wv = 0; wt = 0;
            if (m_cnt > 0 && ($urandom % 3) != 0) begin
                int x;
                x = (m_head + int'($urandom % m_cnt)) % DEPTH;
                if (!m_ready[x]) begin wv = 1; wt = 3'(x); end
            end
            wm = (m_kind[wt] == 2) && (($urandom % 5) == 0);
            we = ($urandom % 40) == 0;
            step(iv, ik, id, wv, wt, $urandom, $urandom, wm, we, lr);
        end

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule